// File: doc/BRIEF.md
# Compressed-Enable CSR Write Legalizer

This block keeps three machine-level control registers: an ISA descriptor word, a machine exception return address and a supervisor exception return address. Software reaches them through one write port and one combinational read port. Every write passes through legalization rules before it is stored.

In the descriptor word only the compressed-instruction enable bit (bit 2) can ever change. A change to it is allowed only under two conditions. First, a static configuration input must mark the descriptor as writable, and compressed instructions must have been enabled at reset. Second, the change must not leave the next fetch address misaligned. Exception return addresses are stored with bit 0 cleared. Bit 1 is kept only when compressed instructions are on now, or could be turned on later. In every other case the stored address is 4-byte aligned.

The ISA register's other bits come from the parameter `ISA_BASE`. Register addresses come from the parameters `ISA_ADDR` (default 0x301), `MEPC_ADDR` (default 0x341) and `SEPC_ADDR` (default 0x141).

Top module: `rvc_csr_guard`

## Requirements
- R1: While reset is asserted and after it is released, the ISA register reads as `ISA_BASE` with bit 2 equal to `cfg_rvc_boot`, and both return-address registers read as zero.
- R2: A write to the ISA address while `cfg_isa_wr_ok` is 0 leaves the ISA register unchanged.
- R3: A write to the ISA address never changes any bit other than bit 2; those bits keep their `ISA_BASE` values whatever the written data.
- R4: A write that would clear bit 2 while `fetch_pc_b1` is 1 in the same cycle is ignored.
- R5: When `cfg_rvc_boot` is 0, no write changes bit 2.
- R6: In all other cases, bit 2 takes `csr_wdata[2]` at the rising clock edge where the write is sampled.
- R7: A write to a return-address register stores the data with only bit 0 cleared when the current bit 2 is 1, or when both `cfg_isa_wr_ok` and `cfg_rvc_boot` are 1.
- R8: In every other case, a return-address write stores the data with bits 1 and 0 cleared.
- R9: Reads are combinational. The ISA, MEPC and SEPC addresses return their stored values, and any other address returns zero. A write to one address or to an unmapped address leaves the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_isa_wr_ok | input | 1 | Static: the ISA register accepts writes |
| cfg_rvc_boot | input | 1 | Static: compressed instructions enabled at reset |
| fetch_pc_b1 | input | 1 | Bit 1 of the next fetch address |
| csr_we | input | 1 | Write enable |
| csr_waddr | input | ADDR_W | Write address |
| csr_wdata | input | XLEN | Write data |
| csr_raddr | input | ADDR_W | Read address |
| csr_rdata | output | XLEN | Read data, combinational |

## Verification
The hardest state to reach from the ports is a compressed bit that differs from its boot value. This state decides both the return-address mask and whether a clear is suppressed. Before each trial, the bench reaches it with a preparatory descriptor write made with writes allowed and fetch bit 1 low. Only after that does it apply the trial's configuration. It then sweeps every reachable mix of the two configuration inputs, the current bit, the requested bit and fetch bit 1. Each trial ends with return-address writes that carry ones in bits 1 and 0, so the chosen mask is visible.

// File: rtl/rvc_csr_pkg.sv
package rvc_csr_pkg;
    // bit position of the compressed-instruction enable in the ISA word
    localparam int CBIT = 2;

    // decision taken on a write to the compressed-enable bit
    typedef enum logic [1:0] {
        CW_TAKE       = 2'd0,
        CW_LOCKED_CFG = 2'd1,
        CW_LOCKED_PC  = 2'd2
    } cwrite_e;
endpackage

// File: rtl/isa_c_legalizer.sv
module isa_c_legalizer
    import rvc_csr_pkg::*;
(
    input  logic    cur_c,
    input  logic    req_c,
    input  logic    wr_ok,
    input  logic    boot_en,
    input  logic    pc_b1,
    output cwrite_e verdict,
    output logic    next_c
);
    always_comb begin
        if (!wr_ok || !boot_en)
            verdict = CW_LOCKED_CFG;
        else if (!req_c && pc_b1)
            verdict = CW_LOCKED_PC;
        else
            verdict = CW_TAKE;
    end

    always_comb begin
        unique case (verdict)
            CW_TAKE:       next_c = req_c;
            CW_LOCKED_CFG: next_c = cur_c;
            CW_LOCKED_PC:  next_c = cur_c;
            default:       next_c = cur_c;
        endcase
    end
endmodule

// File: rtl/epc_legalizer.sv
module epc_legalizer #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] wdata,
    input  logic            c_now,
    input  logic            wr_ok,
    input  logic            boot_en,
    output logic [XLEN-1:0] legal
);
    logic keep_b1;

    always_comb begin
        keep_b1  = c_now | (wr_ok & boot_en);
        legal    = wdata;
        legal[0] = 1'b0;
        if (!keep_b1)
            legal[1] = 1'b0;
    end
endmodule

// File: rtl/rvc_csr_guard.sv
module rvc_csr_guard
    import rvc_csr_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              ADDR_W    = 12,
    parameter logic [XLEN-1:0] ISA_BASE  = 32'h4000_0100,
    parameter logic [ADDR_W-1:0] ISA_ADDR  = 12'h301,
    parameter logic [ADDR_W-1:0] MEPC_ADDR = 12'h341,
    parameter logic [ADDR_W-1:0] SEPC_ADDR = 12'h141
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_isa_wr_ok,
    input  logic              cfg_rvc_boot,
    input  logic              fetch_pc_b1,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_waddr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [ADDR_W-1:0] csr_raddr,
    output logic [XLEN-1:0]   csr_rdata
);
    localparam int NEPC = 2;

    logic            c_q;
    logic            c_next;
    cwrite_e         c_verdict;
    logic            isa_we;
    logic [XLEN-1:0] isa_val;
    logic [XLEN-1:0] epc_legal;
    logic [XLEN-1:0] epc_q [NEPC];
    logic [XLEN-1:0] mepc_q;
    logic [XLEN-1:0] sepc_q;

    assign isa_we = csr_we && (csr_waddr == ISA_ADDR);

    isa_c_legalizer u_cleg (
        .cur_c   (c_q),
        .req_c   (csr_wdata[CBIT]),
        .wr_ok   (cfg_isa_wr_ok),
        .boot_en (cfg_rvc_boot),
        .pc_b1   (fetch_pc_b1),
        .verdict (c_verdict),
        .next_c  (c_next)
    );

    epc_legalizer #(.XLEN(XLEN)) u_eleg (
        .wdata   (csr_wdata),
        .c_now   (c_q),
        .wr_ok   (cfg_isa_wr_ok),
        .boot_en (cfg_rvc_boot),
        .legal   (epc_legal)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= cfg_rvc_boot;
        else if (isa_we && c_verdict == CW_TAKE)
            c_q <= c_next;
    end

    always_comb begin
        isa_val       = ISA_BASE;
        isa_val[CBIT] = c_q;
    end

    for (genvar i = 0; i < NEPC; i++) begin : g_epc
        localparam logic [ADDR_W-1:0] MY_ADDR = (i == 0) ? MEPC_ADDR : SEPC_ADDR;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                epc_q[i] <= '0;
            else if (csr_we && csr_waddr == MY_ADDR)
                epc_q[i] <= epc_legal;
        end
    end

    assign mepc_q = epc_q[0];
    assign sepc_q = epc_q[1];

    always_comb begin
        if (csr_raddr == ISA_ADDR)
            csr_rdata = isa_val;
        else if (csr_raddr == MEPC_ADDR)
            csr_rdata = mepc_q;
        else if (csr_raddr == SEPC_ADDR)
            csr_rdata = sepc_q;
        else
            csr_rdata = '0;
    end
endmodule

// File: rtl/rvc_csr_guard_chk.sv
module rvc_csr_guard_chk #(
    parameter int                XLEN     = 32,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] ISA_ADDR = 12'h301,
    parameter logic [ADDR_W-1:0] MEPC_ADDR = 12'h341
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_isa_wr_ok,
    input logic              cfg_rvc_boot,
    input logic              fetch_pc_b1,
    input logic              csr_we,
    input logic [ADDR_W-1:0] csr_waddr,
    input logic [XLEN-1:0]   csr_wdata,
    input logic              c_q,
    input logic [XLEN-1:0]   mepc_q
);
    logic isa_wr;
    logic mepc_wr;
    assign isa_wr  = csr_we && csr_waddr == ISA_ADDR;
    assign mepc_wr = csr_we && csr_waddr == MEPC_ADDR;

    AST_ISA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        isa_wr && !cfg_isa_wr_ok |=> $stable(c_q)); // R2

    AST_NO_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        isa_wr && !csr_wdata[2] && fetch_pc_b1 |=> $stable(c_q)); // R4

    AST_BOOT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        isa_wr && !cfg_rvc_boot |=> $stable(c_q)); // R5

    AST_C_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        isa_wr && cfg_isa_wr_ok && cfg_rvc_boot && !(fetch_pc_b1 && !csr_wdata[2])
        |=> c_q == $past(csr_wdata[2])); // R6

    AST_EPC_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        mepc_wr |=> !mepc_q[0]); // R7

    AST_EPC_ALIGN4: assert property (@(posedge clk) disable iff (!rst_n)
        mepc_wr && !c_q && !(cfg_isa_wr_ok && cfg_rvc_boot) |=> mepc_q[1:0] == 2'b00); // R8

    AST_EPC_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        isa_wr |=> $stable(mepc_q)); // R9
endmodule

bind rvc_csr_guard rvc_csr_guard_chk #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .ISA_ADDR(ISA_ADDR), .MEPC_ADDR(MEPC_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_isa_wr_ok (cfg_isa_wr_ok),
    .cfg_rvc_boot  (cfg_rvc_boot),
    .fetch_pc_b1   (fetch_pc_b1),
    .csr_we        (csr_we),
    .csr_waddr     (csr_waddr),
    .csr_wdata     (csr_wdata),
    .c_q           (c_q),
    .mepc_q        (mepc_q)
);

// File: tb/sim_rvc_csr_guard.sv
module sim_rvc_csr_guard;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int AW = 12;
    localparam logic [XLEN-1:0] BASE = 32'h4000_0100;
    localparam logic [AW-1:0] A_ISA  = 12'h301;
    localparam logic [AW-1:0] A_MEPC = 12'h341;
    localparam logic [AW-1:0] A_SEPC = 12'h141;
    localparam logic [AW-1:0] A_NONE = 12'h7C0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_isa_wr_ok = 1'b0;
    logic cfg_rvc_boot = 1'b0;
    logic fetch_pc_b1 = 1'b0;
    logic csr_we = 1'b0;
    logic [AW-1:0] csr_waddr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [AW-1:0] csr_raddr = '0;
    logic [XLEN-1:0] csr_rdata;

    int total = 0;
    int bad = 0;
    logic m_c;
    logic [XLEN-1:0] m_mepc, m_sepc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvc_csr_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_isa_wr_ok(cfg_isa_wr_ok),
        .cfg_rvc_boot(cfg_rvc_boot), .fetch_pc_b1(fetch_pc_b1),
        .csr_we(csr_we), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
        .csr_raddr(csr_raddr), .csr_rdata(csr_rdata)
    );

    function automatic logic [XLEN-1:0] isa_exp(input logic c);
        logic [XLEN-1:0] v;
        v = BASE;
        v[2] = c;
        return v;
    endfunction

    task automatic check(input logic [AW-1:0] a, input logic [XLEN-1:0] exp, input string tag);
        csr_raddr = a;
        #1;
        total++;
        if (csr_rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, csr_rdata, exp);
        end
    endtask

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_rvc_boot = boot;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_c = boot;
        m_mepc = '0;
        m_sepc = '0;
    endtask

    // drive at a falling edge, hold across one rising edge, update the model
    task automatic wr(input logic [AW-1:0] a, input logic [XLEN-1:0] d);
        logic keep1;
        @(negedge clk);
        csr_we = 1'b1;
        csr_waddr = a;
        csr_wdata = d;
        keep1 = m_c | (cfg_isa_wr_ok & cfg_rvc_boot);
        if (a == A_ISA) begin
            if (cfg_isa_wr_ok && cfg_rvc_boot && !(!d[2] && fetch_pc_b1))
                m_c = d[2];
        end else if (a == A_MEPC) begin
            m_mepc = d & ~(keep1 ? 32'h1 : 32'h3);
        end else if (a == A_SEPC) begin
            m_sepc = d & ~(keep1 ? 32'h1 : 32'h3);
        end
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset values, checked while reset is held and after release
        cfg_rvc_boot = 1'b1;
        repeat (2) @(negedge clk);
        check(A_ISA, isa_exp(1'b1), "R1 isa in reset");
        check(A_MEPC, '0, "R1 mepc in reset");
        do_reset(1'b0);
        check(A_ISA, isa_exp(1'b0), "R1 isa boot0");
        check(A_SEPC, '0, "R1 sepc");

        for (int boot = 0; boot < 2; boot++) begin
            for (int cur = 0; cur < 2; cur++) begin
                for (int ok = 0; ok < 2; ok++) begin
                    for (int req = 0; req < 2; req++) begin
                        for (int pb = 0; pb < 2; pb++) begin
                            logic [XLEN-1:0] d;
                            if (boot == 0 && cur == 1) continue;
                            do_reset(boot[0]);
                            // reach the trial's starting compressed bit
                            cfg_isa_wr_ok = 1'b1;
                            fetch_pc_b1 = 1'b0;
                            wr(A_ISA, cur[0] ? 32'h4 : 32'h0);
                            check(A_ISA, isa_exp(cur[0]), "R6 setup");
                            cfg_isa_wr_ok = ok[0];
                            fetch_pc_b1 = pb[0];
                            // other bits inverted to expose R3
                            d = ~BASE;
                            d[2] = req[0];
                            wr(A_ISA, d);
                            if (!ok)
                                check(A_ISA, isa_exp(m_c), "R2 locked write");
                            else if (!boot)
                                check(A_ISA, isa_exp(m_c), "R5 boot lock");
                            else if (!req && pb)
                                check(A_ISA, isa_exp(m_c), "R4 misalign guard");
                            else
                                check(A_ISA, isa_exp(m_c), "R3 R6 taken");
                            if (m_c !== ((ok && boot && !(!req && pb)) ? req[0] : cur[0])) begin
                                bad++;
                                $display("FAIL R6 model disagreement");
                            end
                            wr(A_MEPC, 32'hA5A5_A5A7);
                            wr(A_SEPC, 32'h1234_567F);
                            if (m_c || (ok && boot)) begin
                                check(A_MEPC, m_mepc, "R7 mepc");
                                check(A_SEPC, m_sepc, "R7 sepc");
                            end else begin
                                check(A_MEPC, m_mepc, "R8 mepc");
                                check(A_SEPC, m_sepc, "R8 sepc");
                            end
                            wr(A_NONE, 32'hFFFF_FFFF);
                            check(A_NONE, '0, "R9 unmapped read");
                            check(A_MEPC, m_mepc, "R9 mepc isolated");
                            check(A_ISA, isa_exp(m_c), "R9 isa isolated");
                        end
                    end
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule